// File: doc/BRIEF.md
# Four-Phase Handshake Parallel Sender

This block moves parallel words from a local producer onto a point-to-point link that uses a full four-phase request/ready handshake. The local side hands over one word at a time with valid/ready signalling. On the link side the block drives a data bus and a request line and watches a single ready line from the receiver. That ready line has two jobs: when it goes high the receiver can take a word, and when it goes low while the request is up the receiver has captured the word.

All link timing is counted in clock cycles. A setup count fixes how long the data bus is stable before the request rises. A hold count keeps the bus frozen and the local side stalled after the request falls. A cycle count spaces the starts of successive transfers, however quickly the producer offers words. The receiver's ready line is asynchronous to the block and passes through a two-flop synchroniser before any decision uses it. Traffic flows in the sender direction only.

An asynchronous active-low reset, released synchronously inside the block, returns it to idle with the request low, the data bus at zero and the timers expired.

Top module: `hs4_sender`

## Requirements
- R1: No transfer starts while the synchronised receiver ready is low: the data bus and request hold their values. A transfer starts (new word on the data bus) exactly 3 clock cycles after the cycle in which the ready input rises (two synchroniser stages plus one state register).
- R2: The request rises exactly SETUP_CYC cycles after the new word appears on the data bus.
- R3: While the request is high and the receiver ready stays high, the request stays high.
- R4: When the receiver ready falls while the request is high, the request falls exactly 3 cycles after the ready input changes.
- R5: The data bus does not change from the start of one transfer until the start of the next, which covers the whole hold interval after the request falls.
- R6: The local ready output is low from the cycle after a word is accepted until the hold interval has elapsed; when the cycle interval is not the binding limit, it returns high exactly HOLD_CYC cycles after the request falls. Local ready and the request are never high together.
- R7: Starts of successive transfers are at least CYCLE_CYC cycles apart; when the cycle interval is the binding limit, local ready returns high exactly CYCLE_CYC-1 cycles after the previous start.
- R8: Reset drives the request low and the data bus to zero, and after reset the local ready output is high.
- R9: The word sent is the value on the local data input at the clock edge where local valid and local ready are both high; later changes to that input do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_valid | input | 1 | Local producer offers a word |
| src_data | input | DATA_W | Word offered by the local producer |
| src_ready | output | 1 | Block can accept a word this cycle |
| link_data | output | DATA_W | Parallel data bus to the receiver |
| link_req | output | 1 | Request: data on the bus is valid |
| link_rdy | input | 1 | Receiver ready (high) / captured acknowledge (falling), asynchronous |

## Verification
The bench builds the block with an 8-bit bus, a setup count of 3, a hold count of 2 and a cycle count of 12. Distinct setup and hold values make an off-by-one in either timer visible as a wrong cycle difference, and a cycle count larger than one full transfer against a fast receiver makes the cycle timer, not the hold timer, decide when local ready returns, so both release paths are measured. A slow receiver keeps the request up for several cycles and a receiver that stays not-ready stalls a pending word, which reaches the level-sensitive start and acknowledge paths.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SETUP = 3'd2,
    ST_REQ   = 3'd3,
    ST_HOLD  = 3'd4
  } hs4_state_e;

  function automatic int hs4_cnt_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m > 1) ? $clog2(m) + 1 : 1;
  endfunction

endpackage

// File: rtl/hs4_sync2.sv
module hs4_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic meta_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      meta_q <= d;
      out_q  <= meta_q;
    end
  end

  assign q = out_q;

endmodule

// File: rtl/hs4_timer.sv
module hs4_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  // counting down never wraps past zero
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> done);

endmodule

// File: rtl/hs4_ctrl.sv
module hs4_ctrl
  import hs4_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              rdy_s,
  input  logic              setup_done,
  input  logic              hold_done,
  input  logic              cyc_done,
  output logic              setup_load,
  output logic              hold_load,
  output logic              cyc_load,
  output logic              link_req,
  output logic [DATA_W-1:0] link_data
);

  hs4_state_e        state_q, state_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              word_en;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;
  logic              req_q, req_d;

  always_comb begin
    state_d    = state_q;
    word_d     = word_q;
    word_en    = 1'b0;
    data_d     = data_q;
    data_en    = 1'b0;
    setup_load = 1'b0;
    hold_load  = 1'b0;
    cyc_load   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (src_valid && cyc_done) begin
          word_d  = src_data;
          word_en = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rdy_s) begin
          data_d     = word_q;
          data_en    = 1'b1;
          setup_load = 1'b1;
          cyc_load   = 1'b1;
          state_d    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (setup_done) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (!rdy_s) begin
          hold_load = 1'b1;
          state_d   = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (hold_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    req_d = (state_d == ST_REQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign src_ready = (state_q == ST_IDLE) && cyc_done;
  assign link_req  = req_q;
  assign link_data = data_q;

  // R1: a receiver that is not ready stalls the start
  p_no_start_unready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !rdy_s) |=> ($stable(link_data) && !link_req));

  // R2: the bus is already settled when the request rises
  p_setup_before_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_req) |-> $stable(link_data));

  // R3: request held while the receiver keeps ready high
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && rdy_s) |=> link_req);

  // R4: request withdrawn after acknowledge
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && !rdy_s) |=> !link_req);

  // R5: bus only moves at a transfer start
  p_bus_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_WAIT) |=> $stable(link_data));

  // R6: never ready to accept while a request is up
  p_ready_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ready && link_req));

endmodule

// File: rtl/hs4_sender.sv
module hs4_sender
  import hs4_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int CYCLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic [DATA_W-1:0] link_data,
  output logic              link_req,
  input  logic              link_rdy
);

  localparam int CW = hs4_cnt_width(SETUP_CYC, HOLD_CYC, CYCLE_CYC);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] CYCLE_LD = CW'(CYCLE_CYC - 1);

  logic rst_n_i;
  logic rdy_s;
  logic setup_load, hold_load, cyc_load;
  logic setup_done, hold_done, cyc_done;

  hs4_sync2 u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_i)
  );

  hs4_sync2 u_rdy_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (link_rdy),
    .q     (rdy_s)
  );

  hs4_timer #(.W(CW)) u_setup_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (setup_load),
    .load_val (SETUP_LD),
    .done     (setup_done)
  );

  hs4_timer #(.W(CW)) u_hold_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (hold_load),
    .load_val (HOLD_LD),
    .done     (hold_done)
  );

  hs4_timer #(.W(CW)) u_cycle_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (cyc_load),
    .load_val (CYCLE_LD),
    .done     (cyc_done)
  );

  hs4_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .src_valid  (src_valid),
    .src_data   (src_data),
    .src_ready  (src_ready),
    .rdy_s      (rdy_s),
    .setup_done (setup_done),
    .hold_done  (hold_done),
    .cyc_done   (cyc_done),
    .setup_load (setup_load),
    .hold_load  (hold_load),
    .cyc_load   (cyc_load),
    .link_req   (link_req),
    .link_data  (link_data)
  );

  // R8: reset state on the link
  p_reset_idle_r8: assert property (@(posedge clk)
    !rst_n_i |-> (!link_req && link_data == '0));

  // R7: after a start, no new acceptance until the cycle timer runs out
  p_cycle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    cyc_load |=> !src_ready);

endmodule

// File: tb/sim_hs4_sender.sv
module sim_hs4_sender;

  localparam int DW = 8;
  localparam int SU = 3;
  localparam int HO = 2;
  localparam int CY = 12;

  logic          clk;
  logic          rst_n;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          src_ready;
  logic [DW-1:0] link_data;
  logic          link_req;
  logic          link_rdy;

  int n_chk;
  int n_bad;
  int cyc;
  int t_data, t_rise, t_fall, t_ready;
  logic [DW-1:0] prev_data;
  logic          prev_req, prev_ro;
  logic          auto_rx;
  logic          finished;

  hs4_sender #(.DATA_W(DW), .SETUP_CYC(SU), .HOLD_CYC(HO), .CYCLE_CYC(CY)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .link_data (link_data),
    .link_req  (link_req),
    .link_rdy  (link_rdy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event recorder, sampled after each edge has settled
  always @(posedge clk) begin
    #2;
    if (link_data !== prev_data) t_data = cyc;
    if (link_req && !prev_req) t_rise = cyc;
    if (!link_req && prev_req) t_fall = cyc;
    if (src_ready && !prev_ro) t_ready = cyc;
    prev_data = link_data;
    prev_req  = link_req;
    prev_ro   = src_ready;
  end

  // fast receiver model
  always @(negedge clk) begin
    if (auto_rx) begin
      if (link_req && link_rdy) link_rdy <= 1'b0;
      else if (!link_req && !link_rdy) link_rdy <= 1'b1;
    end
  end

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_req(input logic lvl, input string tag);
    int n = 0;
    while (link_req !== lvl && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) chk(tag, 1'b0, int'(link_req), int'(lvl));
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (src_ready !== 1'b1 && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) chk(tag, 1'b0, 0, 1);
  endtask

  // offer one word; returns at the negedge after it was taken
  task automatic send(input logic [DW-1:0] w);
    int n = 0;
    src_valid = 1'b1;
    src_data  = w;
    while (src_ready !== 1'b1 && n < 200) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    src_valid = 1'b0;
    src_data  = ~w;
  endtask

  task automatic t_reset;
    chk("R8 req low after reset", link_req == 1'b0, int'(link_req), 0);
    chk("R8 data zero after reset", link_data == '0, int'(link_data), 0);
    chk("R8 ready high after reset", src_ready == 1'b1, int'(src_ready), 1);
  endtask

  task automatic t_basic;
    int t_drop;
    link_rdy = 1'b1;
    repeat (4) @(negedge clk);
    send(8'hA5);
    wait_req(1'b1, "R2 request never rose");
    chk("R9 captured word", link_data == 8'hA5, int'(link_data), 'hA5);
    chk("R2 setup interval", (t_rise - t_data) == SU, t_rise - t_data, SU);
    chk("R6 ready low during request", src_ready == 1'b0, int'(src_ready), 0);
    repeat (6) @(negedge clk);
    chk("R3 request held while ready", link_req == 1'b1, int'(link_req), 1);
    link_rdy = 1'b0;
    t_drop = cyc;
    wait_req(1'b0, "R4 request never fell");
    chk("R4 acknowledge latency", (t_fall - t_drop) == 3, t_fall - t_drop, 3);
    chk("R5 data at request fall", link_data == 8'hA5, int'(link_data), 'hA5);
    wait_ready("R6 ready never returned");
    chk("R6 hold interval", (t_ready - t_fall) == HO, t_ready - t_fall, HO);
    chk("R5 data through hold", link_data == 8'hA5, int'(link_data), 'hA5);
  endtask

  task automatic t_notready;
    int t_up;
    send(8'h5A);
    repeat (10) @(negedge clk);
    chk("R1 no request while unready", link_req == 1'b0, int'(link_req), 0);
    chk("R1 bus unchanged while unready", link_data == 8'hA5, int'(link_data), 'hA5);
    link_rdy = 1'b1;
    t_up = cyc;
    wait_req(1'b1, "R1 request never rose");
    chk("R1 start latency", (t_data - t_up) == 3, t_data - t_up, 3);
    chk("R9 stalled word", link_data == 8'h5A, int'(link_data), 'h5A);
    link_rdy = 1'b0;
    wait_req(1'b0, "R4 request never fell");
    wait_ready("R6 ready never returned");
  endtask

  task automatic t_cycle;
    int s1;
    link_rdy = 1'b1;
    auto_rx  = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h11);
    wait_req(1'b1, "R7 first request");
    s1 = t_data;
    wait_ready("R7 ready never returned");
    chk("R7 cycle interval binds", (t_ready - s1) == CY - 1, t_ready - s1, CY - 1);
    send(8'h22);
    wait_req(1'b1, "R7 second request");
    chk("R7 start spacing", (t_data - s1) >= CY, t_data - s1, CY);
    chk("R9 second word", link_data == 8'h22, int'(link_data), 'h22);
    wait_ready("R7 ready after second");
    auto_rx = 1'b0;
  endtask

  task automatic t_reset_mid;
    link_rdy = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h77);
    wait_req(1'b1, "R8 request before reset");
    rst_n = 1'b0;
    #1;
    chk("R8 req cleared by reset", link_req == 1'b0, int'(link_req), 0);
    chk("R8 data cleared by reset", link_data == '0, int'(link_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    link_rdy = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 ready after reset", src_ready == 1'b1, int'(src_ready), 1);
  endtask

  initial begin
    finished = 1'b0;
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    t_data = 0; t_rise = 0; t_fall = 0; t_ready = 0;
    prev_data = '0; prev_req = 1'b0; prev_ro = 1'b0;
    auto_rx = 1'b0;
    rst_n = 1'b0;
    src_valid = 1'b0;
    src_data = '0;
    link_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_notready();
    t_cycle();
    t_reset_mid();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule